// File: doc/BRIEF.md
# Disk Controller Maintenance Shift Path

This block models the diagnostic path of a disk controller that sits on the I/O bus of a 12-bit processor. Software issues commands through a strobe and a 3-bit function code. The block decodes three of them. One clears the controller and the accumulator. One copies the accumulator into the disk address register. The third writes a maintenance control word that is taken from the accumulator.

There is no free-running shift clock. In maintenance mode, each maintenance command steps the serial path by one bit. The control word chooses which segments of the address move, and whether the bits that leave them enter the data buffer stage. Five commands with both segment selects set, then seven commands with only the upper select set, carry the whole 12-bit address into the buffer, most significant bit first. A read bit in the control word returns the buffer to the accumulator output. Diagnostics use this round trip to prove the storage and shift chain of the address register.

Top module: `disk_maint_shift`

## Requirements
- R1: After reset, `ac_out` is 0, the buffer stage and address register are 0, and maintenance mode and buffer routing are off.
- R2: A strobed command with `cmd_fn` = 3 stores `ac_in` in the address register. Bits 4..0 form the low segment (sector and surface) and bits 11..5 form the upper segment. The command leaves the buffer stage and `ac_out` unchanged.
- R3: A strobed command with `cmd_fn` = 2 clears `ac_out`, the buffer stage, both address segments, maintenance mode and buffer routing.
- R4: The maintenance command is `cmd_fn` = 7. Its word bit 11 sets maintenance mode, and the mode stays set until a clear. A maintenance command moves nothing unless mode is already set or bit 11 of its own word is set.
- R5: Word bit 10 sets buffer routing, which stays set until a clear. While routing is off, the buffer stage does not change on shifts.
- R6: Word bit 9 selects an upper-segment shift. On each such shift, the segment's top bit enters bit 0 of the buffer stage. After five commands with bits 9 and 7 set and then seven with only bit 9 set, the buffer equals the loaded address.
- R7: Word bit 4 copies the buffer value held before that command into `ac_out`. `ac_out` otherwise changes only on a clear.
- R8: A maintenance command with word bits 9 and 7 both clear shifts nothing.
- R9: Word bit 7 shifts the low segment left by one. With bit 9 also set, the bit that leaves the low segment enters bit 0 of the upper segment. Without bit 9, that bit is lost.
- R10: Commands with function codes other than 2, 3 and 7 have no effect, and so do commands issued with `cmd_stb` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_fn | input | 3 | Function code: 2 clear, 3 load address, 7 maintenance |
| ac_in | input | 12 | Accumulator word sent with the command |
| ac_out | output | 12 | Accumulator value returned by the block |

## Verification
A single maintenance word can both ask for a read-back and shift the buffer stage. The read and the shift then fall on the same edge. The bench provokes this after five shifts by issuing a word with bits 9, 7 and 4 all set. It expects `ac_out` to show the five-bit partial value from before the shift. A following read-only command must then show the six-bit value, which proves that the shift also took place.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam logic [2:0] FN_CLEAR = 3'd2;
  localparam logic [2:0] FN_LOAD  = 3'd3;
  localparam logic [2:0] FN_MAINT = 3'd7;

  localparam int unsigned WB_MODE  = 11;
  localparam int unsigned WB_ROUTE = 10;
  localparam int unsigned WB_UPPER = 9;
  localparam int unsigned WB_LOW   = 7;
  localparam int unsigned WB_READ  = 4;

  typedef struct packed {
    logic clr;
    logic lda;
    logic mnt;
  } dm_evt_t;

  typedef struct packed {
    logic mode;
    logic route;
    logic upper;
    logic low;
    logic rd;
  } dm_sel_t;
endpackage

// File: rtl/dm_decode.sv
module dm_decode
  import dm_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_fn,
  input  logic [AW-1:0] ac_in,
  output dm_evt_t       evt,
  output dm_sel_t       sel
);
  always_comb begin
    evt.clr = cmd_stb && (cmd_fn == FN_CLEAR);
    evt.lda = cmd_stb && (cmd_fn == FN_LOAD);
    evt.mnt = cmd_stb && (cmd_fn == FN_MAINT);
    sel.mode  = ac_in[WB_MODE];
    sel.route = ac_in[WB_ROUTE];
    sel.upper = ac_in[WB_UPPER];
    sel.low   = ac_in[WB_LOW];
    sel.rd    = ac_in[WB_READ];
  end
endmodule

// File: rtl/dm_ctrl.sv
module dm_ctrl
  import dm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dm_evt_t evt,
  input  dm_sel_t sel,
  output logic    low_sh,
  output logic    up_sh,
  output logic    buf_sh,
  output logic    rd_ev
);
  logic mode_q, route_q;
  logic mode_eff, route_eff, step_ok;

  always_comb begin
    mode_eff  = mode_q | sel.mode;
    route_eff = route_q | sel.route;
    step_ok   = evt.mnt & mode_eff;
    low_sh    = step_ok & sel.low;
    up_sh     = step_ok & sel.upper;
    buf_sh    = up_sh & route_eff;
    rd_ev     = evt.mnt & sel.rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      route_q <= 1'b0;
    end else if (evt.clr) begin
      mode_q  <= 1'b0;
      route_q <= 1'b0;
    end else if (evt.mnt) begin
      mode_q  <= mode_eff;
      route_q <= route_eff;
    end
  end

  // R4: once set, mode survives every command except a clear
  p_mode_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !evt.clr) |=> mode_q);
  // R5: routing is sticky in the same way
  p_route_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q && !evt.clr) |=> route_q);
endmodule

// File: rtl/dm_shift.sv
module dm_shift #(
  parameter int unsigned AW  = 12,
  parameter int unsigned LOW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          lda,
  input  logic [AW-1:0] ac_in,
  input  logic          low_sh,
  input  logic          up_sh,
  input  logic          buf_sh,
  output logic [AW-1:0] buf_q
);
  localparam int unsigned UPW = AW - LOW;

  logic [LOW-1:0] low_q;
  logic [UPW-1:0] up_q;
  logic           low_out, up_out;

  function automatic logic [LOW-1:0] push_low(input logic [LOW-1:0] v, input logic b);
    return {v[LOW-2:0], b};
  endfunction

  function automatic logic [UPW-1:0] push_up(input logic [UPW-1:0] v, input logic b);
    return {v[UPW-2:0], b};
  endfunction

  function automatic logic [AW-1:0] push_buf(input logic [AW-1:0] v, input logic b);
    return {v[AW-2:0], b};
  endfunction

  assign low_out = low_sh & low_q[LOW-1];
  assign up_out  = up_q[UPW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      up_q  <= '0;
      buf_q <= '0;
    end else if (clr) begin
      low_q <= '0;
      up_q  <= '0;
      buf_q <= '0;
    end else if (lda) begin
      low_q <= ac_in[LOW-1:0];
      up_q  <= ac_in[AW-1:LOW];
    end else begin
      if (low_sh) low_q <= push_low(low_q, 1'b0);
      if (up_sh)  up_q  <= push_up(up_q, low_out);
      if (buf_sh) buf_q <= push_buf(buf_q, up_out);
    end
  end

  // R6: a buffer shift takes the upper segment's top bit into bit 0
  p_lsb_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_sh && !clr && !lda) |=> (buf_q[0] == $past(up_q[UPW-1])));
  // R8: without a buffer shift or clear the buffer holds
  p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_sh && !clr) |=> $stable(buf_q));
endmodule

// File: rtl/disk_maint_shift.sv
module disk_maint_shift
  import dm_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned LOW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_stb,
  input  logic [2:0]    cmd_fn,
  input  logic [AW-1:0] ac_in,
  output logic [AW-1:0] ac_out
);
  dm_evt_t       evt;
  dm_sel_t       sel;
  logic          low_sh, up_sh, buf_sh, rd_ev;
  logic [AW-1:0] buf_q;

  dm_decode #(.AW(AW)) u_dec (
    .cmd_stb(cmd_stb), .cmd_fn(cmd_fn), .ac_in(ac_in), .evt(evt), .sel(sel)
  );

  dm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel),
    .low_sh(low_sh), .up_sh(up_sh), .buf_sh(buf_sh), .rd_ev(rd_ev)
  );

  dm_shift #(.AW(AW), .LOW(LOW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(evt.clr), .lda(evt.lda), .ac_in(ac_in),
    .low_sh(low_sh), .up_sh(up_sh), .buf_sh(buf_sh), .buf_q(buf_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ac_out <= '0;
    else if (evt.clr)   ac_out <= '0;
    else if (rd_ev)     ac_out <= buf_q;
  end

  // R3: a clear leaves the accumulator at zero
  p_clear_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt.clr |=> (ac_out == '0));
  // R7: accumulator moves only on read or clear
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_ev && !evt.clr) |=> $stable(ac_out));
  // R7: read returns the pre-shift buffer value
  p_read_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !evt.clr) |=> (ac_out == $past(buf_q)));
endmodule

// File: tb/test_disk_maint_shift.sv
`timescale 1ns/1ps
module test_disk_maint_shift;
  localparam logic [2:0] FC = 3'd2, FL = 3'd3, FM = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0;
  logic [2:0]  cmd_fn = 3'd0;
  logic [11:0] ac_in = 12'd0;
  logic [11:0] ac_out;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  disk_maint_shift i_disk_maint_shift (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_fn(cmd_fn),
    .ac_in(ac_in), .ac_out(ac_out)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %o expected %o", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] f, input logic [11:0] a, input logic s = 1'b1);
    @(negedge clk);
    cmd_stb = s; cmd_fn = f; ac_in = a;
    @(negedge clk);
    cmd_stb = 1'b0; cmd_fn = 3'd0; ac_in = 12'd0;
  endtask

  task automatic steps(input logic [11:0] word, input int n);
    for (int i = 0; i < n; i++) cmd(FM, word);
  endtask

  task automatic prep(input logic [11:0] addr);
    cmd(FC, 12'o0001);
    cmd(FL, addr);
    cmd(FM, 12'o4000);
    cmd(FM, 12'o2000);
  endtask

  task automatic t_reset;
    chk("R1 reset ac_out", ac_out, 12'o0000);
    cmd(FM, 12'o0020);
    chk("R1 reset buffer", ac_out, 12'o0000);
  endtask

  task automatic t_roundtrip(input logic [11:0] addr);
    prep(addr);
    chk("R2 load leaves ac_out", ac_out, 12'o0000);
    steps(12'o1200, 5);
    cmd(FM, 12'o0020);
    chk("R6 partial after five", ac_out, {7'd0, addr[11:7]});
    steps(12'o1000, 7);
    cmd(FM, 12'o0020);
    chk("R6 R8 full address back", ac_out, addr);
  endtask

  task automatic t_nomode;
    cmd(FC, 12'o0001);
    cmd(FL, 12'o7777);
    cmd(FM, 12'o2000);
    steps(12'o1200, 12);
    cmd(FM, 12'o0020);
    chk("R4 no shift without mode", ac_out, 12'o0000);
  endtask

  task automatic t_noroute;
    cmd(FC, 12'o0001);
    cmd(FL, 12'o7777);
    cmd(FM, 12'o4000);
    steps(12'o1200, 12);
    cmd(FM, 12'o0020);
    chk("R5 buffer still without routing", ac_out, 12'o0000);
  endtask

  task automatic t_same_cycle;
    prep(12'o5252);
    steps(12'o1200, 5);
    cmd(FM, 12'o1220);
    chk("R7 read sees pre-shift value", ac_out, 12'o0025);
    cmd(FM, 12'o0020);
    chk("R7 shift also happened", ac_out, 12'o0052);
    cmd(FL, 12'o7777);
    chk("R7 R2 load keeps ac_out", ac_out, 12'o0052);
    cmd(FM, 12'o4000);
    chk("R7 non-read maint keeps ac_out", ac_out, 12'o0052);
  endtask

  task automatic t_clear;
    prep(12'o1234);
    steps(12'o1200, 5);
    steps(12'o1000, 7);
    cmd(FM, 12'o0020);
    chk("R3 setup readback", ac_out, 12'o1234);
    cmd(FC, 12'o0000);
    chk("R3 clear zeroes ac_out", ac_out, 12'o0000);
    cmd(FM, 12'o0020);
    chk("R3 clear zeroes buffer", ac_out, 12'o0000);
    cmd(FL, 12'o7777);
    steps(12'o1200, 12);
    cmd(FM, 12'o0020);
    chk("R3 clear drops mode and routing", ac_out, 12'o0000);
  endtask

  task automatic t_lowonly;
    prep(12'o7777);
    steps(12'o0200, 2);
    steps(12'o1200, 5);
    steps(12'o1000, 7);
    cmd(FM, 12'o0020);
    chk("R9 low-only shift loses bits", ac_out, 12'o7774);
  endtask

  task automatic t_badfn;
    cmd(FC, 12'o0000);
    cmd(FL, 12'o0123);
    cmd(FM, 12'o4000);
    cmd(FM, 12'o2000);
    cmd(FL, 12'o7777, 1'b0);
    cmd(FC, 12'o0000, 1'b0);
    cmd(FM, 12'o1220, 1'b0);
    for (int f = 0; f < 8; f++)
      if (f != 2 && f != 3 && f != 7) cmd(3'(f), 12'o7777);
    chk("R10 ignored commands leave ac_out", ac_out, 12'o0000);
    steps(12'o1200, 5);
    steps(12'o1000, 7);
    cmd(FM, 12'o0020);
    chk("R10 address untouched", ac_out, 12'o0123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_roundtrip(12'o2525);
    t_roundtrip(12'o5252);
    t_roundtrip(12'o7777);
    t_roundtrip(12'o0000);
    t_roundtrip(12'o4001);
    t_nomode();
    t_noroute();
    t_same_cycle();
    t_clear();
    t_lowonly();
    t_badfn();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule